// File: doc/BRIEF.md
# I2C Master START Sequencer

This block produces the START condition of an I2C master on open-drain SDA and SCL lines. Software writes a control word whose bit 0 requests a START. The block samples both lines, then times two phases with a down-counter that is reloaded from a 7-bit reload input. After the first phase it pulls SDA low while SCL stays released. That falling edge of SDA while SCL is high is the START. After the second phase the request bit clears and SDA stays held low, ready for the first bit of the transfer that follows.

Bus contention aborts the sequence. This happens if either line is already low when the request is sampled, or if SCL falls before SDA has been pulled low. The block then raises a collision flag, drops the request and releases SDA. While a START is in progress, the block rejects writes to the transmit buffer (raising a write-collision flag) and writes to the five request bits of the control word. Requests are never queued.

Top module: `i2cStartSeq`

## Requirements
- R1: After the asynchronous active-low reset, both drive-low outputs are 0, all four flags are 0, the request bits and the transmit buffer are 0, and the counter is stopped.
- R2: A control write while idle stores `ctrlWrData` into `reqBits`. Bit 0 is the START request; bits 1 to 4 are the other sequence requests, which this block only stores. With bit 0 set, the lines are sampled at the next clock edge. If both are high, the counter loads `reloadVal` and `startSeen` clears. `startSeen` clears at any sampling edge.
- R3: When a START request is written at edge W with reload value R and no contention, `sdaDrvLow` and `startSeen` become 1 at edge W+R+2.
- R4: At edge W+2R+3, `reqBits[0]` clears and `doneIrq` sets. `sdaDrvLow` stays 1 after that edge. `sclDrvLow` is 0 at all times.
- R5: If SDA or SCL is low at the sampling edge W+1, `bclIrq` sets, `reqBits[0]` clears, `sdaDrvLow` is 0, and `startSeen` stays 0. This includes SDA held low by the block's own previous START.
- R6: Between edges W+2 and W+R+2, if SCL is low at any edge, or SDA is low at edge W+R+2, that edge aborts the sequence. `bclIrq` sets, `reqBits[0]` clears and SDA is never pulled low.
- R7: A transmit-buffer write while `reqBits[0]` is 1 sets `wcolFlag` and leaves `txBuf` unchanged. While idle, the write loads `txBuf` and leaves `wcolFlag` alone.
- R8: A control write while `reqBits[0]` is 1 leaves all five request bits unchanged.
- R9: The flags are sticky. `flagClr` bit 0 clears `wcolFlag`, bit 1 `bclIrq`, bit 2 `doneIrq` and bit 3 `startSeen`. Each bit clears only its own flag, and a set in the same cycle wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctrlWrEn | input | 1 | Control word write strobe |
| ctrlWrData | input | 5 | Request bits; bit 0 = START request |
| reloadVal | input | 7 | Counter reload value (phase = value+1 clocks) |
| txWrEn | input | 1 | Transmit buffer write strobe |
| txWrData | input | 8 | Transmit buffer write data |
| flagClr | input | 4 | Flag clear pulses: wcol, bcl, done, startSeen |
| sdaIn | input | 1 | Sampled SDA line level (already synchronized) |
| sclIn | input | 1 | Sampled SCL line level (already synchronized) |
| sdaDrvLow | output | 1 | Pull SDA low when 1 |
| sclDrvLow | output | 1 | Pull SCL low when 1 |
| reqBits | output | 5 | Current request bits |
| txBuf | output | 8 | Transmit buffer contents |
| startSeen | output | 1 | START condition generated |
| doneIrq | output | 1 | START sequence complete |
| bclIrq | output | 1 | Bus collision |
| wcolFlag | output | 1 | Transmit-buffer write collision |

## Verification
The bench builds the block with the default 7-bit reload and 8-bit buffer. It draws reload values from the whole range, including 0 (phases of one clock) and 127 (the longest phases), so the W+R+2 and W+2R+3 edges are checked at both extremes. The bench models the open-drain wiring, so the line the block samples is the AND of the bench level and the block's release. This makes the case where the block's own held SDA causes a collision reachable. A random SCL drop at each edge of phase one, and buffer and control writes scattered through busy windows, cover every abort point and every lockout cycle.

// File: rtl/i2cStartPkg.sv
package i2cStartPkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_HOLD1 = 2'd1,
    ST_HOLD2 = 2'd2
  } seqState_t;

  typedef struct packed {
    logic loadCnt;
    logic decCnt;
    logic sdaSet;
    logic sdaClr;
    logic startSet;
    logic startClr;
    logic doneSet;
    logic bclSet;
    logic reqClr;
  } seqStrobes_t;
endpackage

// File: rtl/i2cStartCtrl.sv
module i2cStartCtrl
  import i2cStartPkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        startReq,
  input  logic        cntZero,
  input  logic        sdaIn,
  input  logic        sclIn,
  output seqStrobes_t strb
);
  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (startReq) begin
          strb.startClr = 1'b1;
          if (sdaIn && sclIn) begin
            strb.loadCnt = 1'b1;
            stateNxt     = ST_HOLD1;
          end else begin
            strb.bclSet = 1'b1;
            strb.reqClr = 1'b1;
            strb.sdaClr = 1'b1;
          end
        end
      end
      ST_HOLD1: begin
        if (!sclIn || (cntZero && !sdaIn)) begin
          strb.bclSet = 1'b1;
          strb.reqClr = 1'b1;
          strb.sdaClr = 1'b1;
          stateNxt    = ST_IDLE;
        end else if (cntZero) begin
          strb.sdaSet   = 1'b1;
          strb.startSet = 1'b1;
          strb.loadCnt  = 1'b1;
          stateNxt      = ST_HOLD2;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      ST_HOLD2: begin
        if (cntZero) begin
          strb.doneSet = 1'b1;
          strb.reqClr  = 1'b1;
          stateNxt     = ST_IDLE;
        end else begin
          strb.decCnt = 1'b1;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  // R6: SCL low during the first phase always returns the sequencer to idle
  a_r6_scl_low_aborts: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD1 && !sclIn) |=> (state == ST_IDLE));

  // R5: a request sampled with a low line never enters a timing phase
  a_r5_low_line_no_phase: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE && startReq && !(sdaIn && sclIn)) |=> (state == ST_IDLE));
endmodule

// File: rtl/i2cStartDp.sv
module i2cStartDp
  import i2cStartPkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int DATA_W   = 8,
  parameter int REQ_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobes_t         strb,
  input  logic                ctrlWrEn,
  input  logic [REQ_W-1:0]    ctrlWrData,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                txWrEn,
  input  logic [DATA_W-1:0]   txWrData,
  input  logic [3:0]          flagClr,
  output logic                cntZero,
  output logic                busy,
  output logic                sdaHold,
  output logic [REQ_W-1:0]    reqBits,
  output logic [DATA_W-1:0]   txBuf,
  output logic                startSeen,
  output logic                doneIrq,
  output logic                bclIrq,
  output logic                wcolFlag
);
  localparam int FLAG_N = 4;
  localparam logic [RELOAD_W-1:0] CNT_ZERO = '0;

  logic [RELOAD_W-1:0] cnt;
  logic [FLAG_N-1:0]   flagQ;
  logic [FLAG_N-1:0]   flagSet;
  logic [FLAG_N-1:0]   flagDrop;

  assign busy    = reqBits[0];
  assign cntZero = (cnt == CNT_ZERO);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            cnt <= '0;
    else if (strb.loadCnt) cnt <= reloadVal;
    else if (strb.decCnt)  cnt <= cnt - 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 reqBits <= '0;
    else if (strb.reqClr)      reqBits[0] <= 1'b0;
    else if (ctrlWrEn && !busy) reqBits <= ctrlWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 txBuf <= '0;
    else if (txWrEn && !busy)  txBuf <= txWrData;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            sdaHold <= 1'b0;
    else if (strb.sdaSet) sdaHold <= 1'b1;
    else if (strb.sdaClr) sdaHold <= 1'b0;
  end

  // flag order: 0 wcol, 1 bus collision, 2 done, 3 start seen
  assign flagSet  = {strb.startSet, strb.doneSet, strb.bclSet, txWrEn && busy};
  assign flagDrop = {flagClr[3] || strb.startClr, flagClr[2:0]};

  for (genvar i = 0; i < FLAG_N; i++) begin : g_flag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)            flagQ[i] <= 1'b0;
      else if (flagSet[i])  flagQ[i] <= 1'b1;
      else if (flagDrop[i]) flagQ[i] <= 1'b0;
    end
  end

  assign wcolFlag  = flagQ[0];
  assign bclIrq    = flagQ[1];
  assign doneIrq   = flagQ[2];
  assign startSeen = flagQ[3];

  // R2: a load strobe places the reload value in the counter
  a_r2_cnt_load: assert property (@(posedge clk) disable iff (!rstN)
    strb.loadCnt |=> (cnt == $past(reloadVal)));

  // R7: buffer write during a START keeps the buffer and flags the collision
  a_r7_wcol: assert property (@(posedge clk) disable iff (!rstN)
    (txWrEn && busy) |=> ($stable(txBuf) && wcolFlag));

  // R8: request bits above bit 0 never change while busy
  a_r8_req_lock: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> (reqBits[REQ_W-1:1] == $past(reqBits[REQ_W-1:1])));

  // R4: completion leaves SDA held low
  a_r4_done_holds_sda: assert property (@(posedge clk) disable iff (!rstN)
    strb.doneSet |=> sdaHold);
endmodule

// File: rtl/i2cStartSeq.sv
module i2cStartSeq
  import i2cStartPkg::*;
#(
  parameter int RELOAD_W = 7,
  parameter int DATA_W   = 8,
  parameter int REQ_W    = 5
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                ctrlWrEn,
  input  logic [REQ_W-1:0]    ctrlWrData,
  input  logic [RELOAD_W-1:0] reloadVal,
  input  logic                txWrEn,
  input  logic [DATA_W-1:0]   txWrData,
  input  logic [3:0]          flagClr,
  input  logic                sdaIn,
  input  logic                sclIn,
  output logic                sdaDrvLow,
  output logic                sclDrvLow,
  output logic [REQ_W-1:0]    reqBits,
  output logic [DATA_W-1:0]   txBuf,
  output logic                startSeen,
  output logic                doneIrq,
  output logic                bclIrq,
  output logic                wcolFlag
);
  seqStrobes_t strb;
  logic cntZero;
  logic busy;
  logic sdaHold;

  i2cStartCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .startReq (busy),
    .cntZero  (cntZero),
    .sdaIn    (sdaIn),
    .sclIn    (sclIn),
    .strb     (strb)
  );

  i2cStartDp #(
    .RELOAD_W (RELOAD_W),
    .DATA_W   (DATA_W),
    .REQ_W    (REQ_W)
  ) uDp (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .ctrlWrEn   (ctrlWrEn),
    .ctrlWrData (ctrlWrData),
    .reloadVal  (reloadVal),
    .txWrEn     (txWrEn),
    .txWrData   (txWrData),
    .flagClr    (flagClr),
    .cntZero    (cntZero),
    .busy       (busy),
    .sdaHold    (sdaHold),
    .reqBits    (reqBits),
    .txBuf      (txBuf),
    .startSeen  (startSeen),
    .doneIrq    (doneIrq),
    .bclIrq     (bclIrq),
    .wcolFlag   (wcolFlag)
  );

  assign sdaDrvLow = sdaHold;
  assign sclDrvLow = 1'b0;

  // R4: the START request only ever ends with completion or collision reported
  a_r4_req_end_flagged: assert property (@(posedge clk) disable iff (!rstN)
    $fell(reqBits[0]) |-> (doneIrq || bclIrq));

  // R3: SDA is pulled low only while SCL is high or already after START
  a_r3_sda_fall_scl_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sdaDrvLow) |-> $past(sclIn));
endmodule

// File: tb/tb_i2cStartSeq.sv
module tb_i2cStartSeq;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       ctrlWrEn = 1'b0;
  logic [4:0] ctrlWrData = '0;
  logic [6:0] reloadVal = '0;
  logic       txWrEn = 1'b0;
  logic [7:0] txWrData = '0;
  logic [3:0] flagClr = '0;
  logic       sdaExt = 1'b1;
  logic       sclExt = 1'b1;
  logic       sdaIn, sclIn;
  logic       sdaDrvLow, sclDrvLow;
  logic [4:0] reqBits;
  logic [7:0] txBuf;
  logic       startSeen, doneIrq, bclIrq, wcolFlag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  assign sdaIn = sdaExt & ~sdaDrvLow;
  assign sclIn = sclExt & ~sclDrvLow;

  i2cStartSeq dut (
    .clk(clk), .rstN(rstN), .ctrlWrEn(ctrlWrEn), .ctrlWrData(ctrlWrData),
    .reloadVal(reloadVal), .txWrEn(txWrEn), .txWrData(txWrData),
    .flagClr(flagClr), .sdaIn(sdaIn), .sclIn(sclIn), .sdaDrvLow(sdaDrvLow),
    .sclDrvLow(sclDrvLow), .reqBits(reqBits), .txBuf(txBuf),
    .startSeen(startSeen), .doneIrq(doneIrq), .bclIrq(bclIrq),
    .wcolFlag(wcolFlag)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  // expected SDA drive after edge n of a clean START with reload r
  function automatic logic expSda(input int n, input int r);
    return n >= r + 2;
  endfunction

  function automatic int endEdge(input int mode, input int r, input int c);
    case (mode)
      0: return 2 * r + 3;
      1: return c + 1;
      2: return 1;
      default: return r + 2;
    endcase
  endfunction

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    ctrlWrEn = 0; txWrEn = 0; flagClr = 0; sdaExt = 1; sclExt = 1;
    #2;
    rstN = 1'b1;
    tick();
  endtask

  // mode 0 clean, 1 SCL low before edge c+1, 2 SDA low at sampling, 3 SDA low at phase-1 end
  task automatic runStart(input int r, input int mode, input int c, input bit noise);
    int last;
    logic [7:0] expBuf;
    logic expWcol;
    last = endEdge(mode, r, c);
    expBuf = txBuf;
    expWcol = 1'b0;
    reloadVal = 7'(r);
    ctrlWrEn = 1'b1; ctrlWrData = 5'b00001;
    if (mode == 2) sdaExt = 1'b0;
    if (mode == 1 && c == 0) sclExt = 1'b0;
    tick();
    ctrlWrEn = 1'b0;
    chk("R2", {31'd0, reqBits[0]}, 32'd1);
    for (int n = 1; n <= last; n++) begin
      if (mode == 1 && n == c + 1) sclExt = 1'b0;
      if (mode == 3 && n == r + 2) sdaExt = 1'b0;
      if (noise && ($urandom % 4) == 0) begin
        ctrlWrEn = 1'b1; ctrlWrData = 5'($urandom);
      end
      if (noise && ($urandom % 4) == 0) begin
        txWrEn = 1'b1; txWrData = 8'($urandom); expWcol = 1'b1;
      end
      tick();
      ctrlWrEn = 1'b0; txWrEn = 1'b0;
      chk("R8", {27'd0, reqBits}, {31'd0, n < last});
      chk("R7", {24'd0, txBuf}, {24'd0, expBuf});
      chk("R4", {31'd0, sclDrvLow}, 32'd0);
      if (mode == 0) chk("R3", {31'd0, sdaDrvLow}, {31'd0, expSda(n, r)});
      else           chk("R6", {31'd0, sdaDrvLow}, 32'd0);
    end
    chk("R7", {31'd0, wcolFlag}, {31'd0, expWcol});
    if (mode == 0) begin
      chk("R4", {31'd0, doneIrq}, 32'd1);
      chk("R3", {31'd0, startSeen}, 32'd1);
      chk("R4", {31'd0, bclIrq}, 32'd0);
    end else begin
      chk(mode == 2 || (mode == 1 && c == 0) ? "R5" : "R6", {31'd0, bclIrq}, 32'd1);
      chk("R5", {31'd0, startSeen}, 32'd0);
      chk("R6", {31'd0, doneIrq}, 32'd0);
    end
    sdaExt = 1'b1; sclExt = 1'b1;
  endtask

  initial begin
    void'($urandom(32'd20251));
    doReset();
    // R1 reset state
    chk("R1", {31'd0, sdaDrvLow}, 32'd0);
    chk("R1", {31'd0, sclDrvLow}, 32'd0);
    chk("R1", {27'd0, reqBits}, 32'd0);
    chk("R1", {24'd0, txBuf}, 32'd0);
    chk("R1", {28'd0, startSeen, doneIrq, bclIrq, wcolFlag}, 32'd0);

    // R2/R8 idle control write stores other request bits without starting
    ctrlWrEn = 1; ctrlWrData = 5'b11110; tick(); ctrlWrEn = 0;
    tick();
    chk("R2", {27'd0, reqBits}, 32'h1E);
    chk("R2", {31'd0, sdaDrvLow}, 32'd0);

    // R7 idle buffer write loads
    txWrEn = 1; txWrData = 8'hA5; tick(); txWrEn = 0;
    chk("R7", {24'd0, txBuf}, 32'hA5);
    chk("R7", {31'd0, wcolFlag}, 32'd0);

    // directed clean STARTs at reload extremes
    doReset(); runStart(0, 0, 0, 1'b0);
    doReset(); runStart(127, 0, 0, 1'b1);
    doReset(); runStart(1, 0, 0, 1'b1);

    // R4 SDA stays held afterwards; R5 own hold collides, clearing startSeen
    repeat (3) tick();
    chk("R4", {31'd0, sdaDrvLow}, 32'd1);
    ctrlWrEn = 1; ctrlWrData = 5'b00001; tick(); ctrlWrEn = 0;
    tick();
    chk("R5", {31'd0, bclIrq}, 32'd1);
    chk("R5", {31'd0, startSeen}, 32'd0);
    chk("R5", {31'd0, sdaDrvLow}, 32'd0);
    chk("R5", {31'd0, reqBits[0]}, 32'd0);

    // R9 selective clears
    flagClr = 4'b0010; tick(); flagClr = 0;
    chk("R9", {31'd0, bclIrq}, 32'd0);
    chk("R9", {31'd0, doneIrq}, 32'd1);
    flagClr = 4'b0100; tick(); flagClr = 0;
    chk("R9", {31'd0, doneIrq}, 32'd0);

    // directed collisions
    doReset(); runStart(5, 2, 0, 1'b0);
    doReset(); runStart(5, 1, 0, 1'b0);
    doReset(); runStart(5, 1, 6, 1'b0);
    doReset(); runStart(5, 3, 0, 1'b1);
    // R9 wcol clears alone
    doReset(); runStart(3, 0, 0, 1'b0);
    txWrEn = 1; txWrData = 8'h3C;
    ctrlWrEn = 1; ctrlWrData = 5'b00001; tick();
    txWrEn = 0; ctrlWrEn = 0;
    tick(); // sampling edge: collision from held SDA
    chk("R7", {31'd0, wcolFlag}, 32'd0);
    chk("R7", {24'd0, txBuf}, 32'h3C);
    flagClr = 4'b0001; tick(); flagClr = 0;
    chk("R9", {31'd0, bclIrq}, 32'd1);

    // random runs
    for (int k = 0; k < 40; k++) begin
      int r, m, c;
      r = int'($urandom % 128);
      m = int'($urandom % 4);
      c = int'($urandom % (r + 2));
      doReset();
      runStart(r, m, c, 1'b1);
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule